// File: doc/BRIEF.md
# Equality-Set PWM Generator with Period-Buffered Duty

This block produces a pulse-width-modulated waveform from a free-running up-counter of `CNT_W` bits. A stored duty code is compared for equality against the counter. A match sets a clocked set/reset flip-flop, and that flip-flop drives the PWM output. The counter's roll-over from all-ones to zero clears it again. One switching period is therefore 2^CNT_W clock cycles, and 2^CNT_W distinct duty steps exist per period. The switching frequency is the clock frequency divided by that number.

The duty input is a plain level, not a stream, so no valid/ready pair and no back-pressure are involved. The block samples the duty input only in the roll-over cycle, which is the cycle the overflow strobe is high. A controller may change it at any other time without disturbing the period in progress.

The output sense is inverted with respect to the code. The output is low from the start of a period up to and including the cycle in which the counter equals the code. It is high for the rest of the period. Code 0 therefore gives the widest pulse, and code all-ones gives no pulse at all.

Top module: `srl_pwm`

## Requirements
- R1: The counter starts at 0 after reset and steps by one every clock. From all-ones it wraps to 0, so each period is exactly 2^CNT_W cycles long.
- R2: `ovf_o` is high in exactly one cycle per period: the cycle in which the counter holds all-ones (counter position 2^CNT_W-1).
- R3: With a stored code d below all-ones, `pwm_o` is low in counter positions 0..d and high from position d+1 onward. It rises on the clock after the counter equals d.
- R4: The overflow clears `pwm_o` on the clock after the all-ones position, and the overflow has priority over the set. For stored code all-ones, `pwm_o` stays low for the whole period.
- R5: The stored code is loaded from `duty_i` only on the clock that ends an overflow cycle. A value on `duty_i` at any other time has no effect on the waveform of the current period or any later period.
- R6: For stored code d, `pwm_o` is high for 2^CNT_W-1-d cycles of the period.
- R7: A synchronous reset clears the counter, the flip-flop and the stored code. While reset is high, `pwm_o` and `ovf_o` are low. The first period after reset behaves as code 0, whatever `duty_i` held during reset.
- R8: Code 0 gives the maximum high time of 2^CNT_W-1 cycles. The output is low only in counter position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | CNT_W | Duty code for the next period, sampled in the overflow cycle |
| pwm_o | output | 1 | PWM output, driven by the set/reset flip-flop |
| ovf_o | output | 1 | High during the cycle in which the counter holds all-ones |

## Verification
The set from the equality match and the clear from the roll-over fall on the same clock edge when the stored code is all-ones. Two other events also meet on one edge: loading a new code and ending the period that used the old one. The bench provokes the first case by sweeping every code, including all-ones, through consecutive periods. It judges the result by counting the high cycles of each period against 2^CNT_W-1-d, so a single stray high cycle is caught. The second case is provoked by scrambling `duty_i` in every non-overflow cycle and presenting the intended code only in the overflow cycle. Any early or late sampling then shows up as a wrong waveform position in the following period.

// File: rtl/srl_pwm_pkg.sv
package srl_pwm_pkg;
  typedef enum logic {
    PWM_LO = 1'b0,
    PWM_HI = 1'b1
  } pwm_lvl_e;
endpackage

// File: rtl/srl_pwm_ramp.sv
module srl_pwm_ramp #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == TOP);

  // R1: counter steps by one below the top value
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != TOP) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  // R1: wrap to zero after the top value
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/srl_pwm_dutyreg.sv
module srl_pwm_dutyreg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] duty_o
);
  logic [CNT_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst)         duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

  assign duty_o = duty_q;

  // R5: stored code only changes on a load
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(duty_q));
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (duty_q == $past(duty_i)));
endmodule

// File: rtl/srl_pwm_srff.sv
module srl_pwm_srff
  import srl_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             clr_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] bit_eq;
  logic             hit;
  pwm_lvl_e         lvl_q;

  for (genvar b = 0; b < CNT_W; b++) begin : g_eq
    assign bit_eq[b] = ~(cnt_i[b] ^ duty_i[b]);
  end
  assign hit = &bit_eq;

  always_ff @(posedge clk) begin
    if (rst)        lvl_q <= PWM_LO;
    else if (clr_i) lvl_q <= PWM_LO;
    else if (hit)   lvl_q <= PWM_HI;
  end

  assign pwm_o = (lvl_q == PWM_HI);

  // R4: clear has priority over set
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (lvl_q == PWM_LO));
  // R3: equality sets the output
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    ((cnt_i == duty_i) && !clr_i) |=> (lvl_q == PWM_HI));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    ((cnt_i != duty_i) && !clr_i) |=> $stable(lvl_q));
endmodule

// File: rtl/srl_pwm.sv
module srl_pwm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_cur;
  logic             wrap;

  srl_pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  srl_pwm_dutyreg #(.CNT_W(CNT_W)) u_duty (
    .clk    (clk),
    .rst    (rst),
    .load_i (wrap),
    .duty_i (duty_i),
    .duty_o (duty_cur)
  );

  srl_pwm_srff #(.CNT_W(CNT_W)) u_srff (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt),
    .duty_i (duty_cur),
    .clr_i  (wrap),
    .pwm_o  (pwm_o)
  );

  assign ovf_o = wrap;

  // R7: reset clears output and strobe
  a_r7_reset: assert property (@(posedge clk)
    rst |=> (!pwm_o && !ovf_o));
  // R2: overflow strobe lasts a single cycle
  a_r2_single: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o);
  // R4: output is low right after an overflow
  a_r4_low_after_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !pwm_o);
endmodule

// File: tb/tb_srl_pwm.sv
`timescale 1ns/1ps
module tb_srl_pwm;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty_i = '0;
  logic         pwm_o;
  logic         ovf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  srl_pwm #(.CNT_W(W)) dut (
    .clk    (clk),
    .rst    (rst),
    .duty_i (duty_i),
    .pwm_o  (pwm_o),
    .ovf_o  (ovf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one period from counter position 0; starts just after a falling edge.
  // The current stored code is cur; nxt is presented only in the overflow cycle.
  task automatic run_period(input int cur, input int nxt, input int seed);
    int high = 0;
    for (int p = 0; p <= MAX; p++) begin
      duty_i = (p == MAX) ? W'(nxt) : W'(seed * 7 + p * 5 + 3);
      #1;
      chk("R2 ovf strobe", int'(ovf_o), (p == MAX) ? 1 : 0);
      chk("R3/R4 pwm level", int'(pwm_o), (p > cur) ? 1 : 0);
      if (pwm_o) high++;
      @(negedge clk);
    end
    chk("R6 high count", high, MAX - cur);
    if (cur == 0)   chk("R8 code zero width", high, MAX);
    if (cur == MAX) chk("R4 all-ones no pulse", high, 0);
  endtask

  initial begin
    int prev;
    rst = 1'b1;
    duty_i = W'(9);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 reset pwm", int'(pwm_o), 0);
    chk("R7 reset ovf", int'(ovf_o), 0);
    @(negedge clk);
    rst = 1'b0;
    // R7: first period after reset uses code 0; R5: scrambled input ignored
    prev = 0;
    for (int d = 0; d <= MAX; d++) begin
      run_period(prev, d, d);
      prev = d;
    end
    for (int d = MAX; d >= 0; d--) begin
      run_period(prev, d, d + 11);
      prev = d;
    end
    run_period(prev, 3, 5);
    prev = 3;
    // mid-period reset while output is high
    for (int p = 0; p < 8; p++) @(negedge clk);
    #1;
    chk("R3 high before reset", int'(pwm_o), 1);
    rst = 1'b1;
    duty_i = W'(12);
    @(negedge clk);
    #1;
    chk("R7 mid reset pwm", int'(pwm_o), 0);
    chk("R7 mid reset ovf", int'(ovf_o), 0);
    @(negedge clk);
    rst = 1'b0;
    run_period(0, 6, 2);   // R7: behaves as code 0
    run_period(6, 6, 4);
    run_period(6, MAX, 8);
    run_period(MAX, 1, 9);
    run_period(1, 0, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule